// File: doc/BRIEF.md
# Hot-Plug Detect Interrupt Controller

This block watches the hot-plug detect line of a digital video output. The raw line enters through a clock-domain synchroniser. The resolved level is then offered as a readable status bit, and it also gates the output driver: a low level turns the driver off. A change of level, in either direction, latches an event, but only while the digital video output is the selected path. The event appears on an active-low interrupt pin when the interrupt enable bit is set.

The host acknowledges an event by raising a re-arm control bit and then lowering it again. While that bit is high, edges on the line are ignored and the internal reference level follows the line. As a result, a line that has settled to a new level before the bit is released does not raise a fresh interrupt. The enable bit masks the pin only. A latched event survives a masked period and shows on the pin once the mask is lifted.

Top module: `hpd_irq_ctrl`

## Requirements
- R1: `hpd_level_o` shows the level of `hpd_raw_i` with a latency of SYNC_STAGES+1 clock edges. With the default of 2 stages, a change driven before edge k is visible after edge k+2.
- R2: `drv_en_o` is 1 exactly when the resolved detect level is 1, and it is 0 while that level is 0.
- R3: While `dvi_sel_i` is 1, a rising or a falling change of the detect line latches an event. With `irq_en_i` at 1, `irq_n_o` goes to 0 after edge k+3 for a change driven before edge k.
- R4: While `dvi_sel_i` is 0, changes of the detect line latch no event, and `irq_n_o` stays 1.
- R5: `irq_n_o` is 0 only when `irq_en_i` is 1 and an event is latched. A latched event is kept while `irq_en_i` is 0 and reaches the pin once `irq_en_i` returns to 1.
- R6: Once latched, an event stays latched through further toggles of the line. It is cleared only when `irq_rst_i` has been 1 and then returns to 0.
- R7: Line changes that occur while `irq_rst_i` is 1 raise no event after the bit returns to 0. The reference level is taken from the line as it stands at release.
- R8: Synchronous reset `rst` drives `irq_n_o` to 1 and `hpd_level_o` and `drv_en_o` to 0. A detect line already high when reset is released raises no event.
- R9: Holding `irq_rst_i` at 1 without returning it to 0 does not release an asserted interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hpd_raw_i | input | 1 | Asynchronous hot-plug detect line |
| dvi_sel_i | input | 1 | 1 when the digital video output is the selected path |
| irq_en_i | input | 1 | Interrupt enable control bit |
| irq_rst_i | input | 1 | Re-arm control bit, pulsed high then low by the host |
| hpd_level_o | output | 1 | Readable resolved detect level |
| irq_n_o | output | 1 | Active-low interrupt |
| drv_en_o | output | 1 | Output driver enable |

## Verification
The bench sweeps every combination of path select, enable and edge direction, and checks the exact edge on which the level and the interrupt move. A design that compares against a stale reference would fire at reset release with the line high, or would fire after a re-arm during which the line moved. A design that clears on the rising half of the re-arm pulse would drop the interrupt while the bit is still held high. A design that clears the event instead of masking it would lose the event that should reappear when enable returns.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
  // Host-side control bits grouped for the event core
  typedef struct packed {
    logic dvi_sel;
    logic irq_en;
    logic irq_rst;
  } hpd_ctrl_t;

  localparam int unsigned HPD_SYNC_DEFAULT = 2;
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  // Shift register of flops; STAGES must be at least 2
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else begin
      sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/hpd_event.sv
module hpd_event
  import hpd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      level_i,
  input  hpd_ctrl_t ctrl_i,
  output logic      evt_o
);
  // Cycles after reset before the synchronised level is trusted
  localparam int unsigned PRIME = SYNC_STAGES + 1;
  localparam int unsigned CW    = $clog2(PRIME + 1);
  localparam logic [CW-1:0] PRIME_END = CW'(PRIME);

  logic [CW-1:0] prime_q;
  logic          ref_q;
  logic          rearm_q;
  logic          evt_q;
  logic          primed;
  logic          release_now;
  logic          watch;

  assign primed      = (prime_q == PRIME_END);
  assign release_now = rearm_q && !ctrl_i.irq_rst;
  assign watch       = primed && !ctrl_i.irq_rst && !rearm_q && ctrl_i.dvi_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      prime_q <= '0;
      ref_q   <= 1'b0;
      rearm_q <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      if (!primed) begin
        prime_q <= prime_q + 1'b1;
      end
      rearm_q <= ctrl_i.irq_rst;
      ref_q   <= level_i;
      if (release_now) begin
        evt_q <= 1'b0;
      end else if (watch && (level_i != ref_q)) begin
        evt_q <= 1'b1;
      end
    end
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/hpd_irq_ctrl.sv
module hpd_irq_ctrl
  import hpd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = HPD_SYNC_DEFAULT
) (
  input  logic clk,
  input  logic rst,
  input  logic hpd_raw_i,
  input  logic dvi_sel_i,
  input  logic irq_en_i,
  input  logic irq_rst_i,
  output logic hpd_level_o,
  output logic irq_n_o,
  output logic drv_en_o
);
  logic      level_s;
  logic      evt;
  hpd_ctrl_t ctrl;

  assign ctrl = '{dvi_sel: dvi_sel_i, irq_en: irq_en_i, irq_rst: irq_rst_i};

  hpd_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (hpd_raw_i),
    .q_o (level_s)
  );

  hpd_event #(.SYNC_STAGES(SYNC_STAGES)) event_i (
    .clk     (clk),
    .rst     (rst),
    .level_i (level_s),
    .ctrl_i  (ctrl),
    .evt_o   (evt)
  );

  // Registered outputs
  logic level_q, drv_q, irq_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
      drv_q   <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      level_q <= level_s;
      drv_q   <= level_s;
      irq_n_q <= !(evt && ctrl.irq_en);
    end
  end

  assign hpd_level_o = level_q;
  assign drv_en_o    = drv_q;
  assign irq_n_o     = irq_n_q;
endmodule

// File: rtl/hpd_irq_ctrl_chk.sv
module hpd_irq_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic hpd_raw_i,
  input logic dvi_sel_i,
  input logic irq_en_i,
  input logic irq_rst_i,
  input logic hpd_level_o,
  input logic irq_n_o,
  input logic drv_en_o
);
  assert_drv_tracks_level_R2: assert property (@(posedge clk) disable iff (rst)
    drv_en_o == hpd_level_o);

  assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
    !irq_n_o |-> $past(irq_en_i));

  assert_irq_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (!irq_n_o && irq_en_i && !irq_rst_i && !$past(irq_rst_i) && !$past(irq_rst_i, 2))
      |=> !irq_n_o);

  assert_release_has_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_n_o) |-> (!$past(irq_en_i) || $past(irq_rst_i, 3)));

  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (irq_n_o && !drv_en_o && !hpd_level_o));
endmodule

bind hpd_irq_ctrl hpd_irq_ctrl_chk chk_i (.*);

// File: tb/hpd_irq_ctrl_tb_top.sv
module hpd_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, raw, dsel, en, rbit;
  logic level, irq_n, drv;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpd_irq_ctrl dut_i (
    .clk (clk), .rst (rst), .hpd_raw_i (raw), .dvi_sel_i (dsel),
    .irq_en_i (en), .irq_rst_i (rbit),
    .hpd_level_o (level), .irq_n_o (irq_n), .drv_en_o (drv)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rearm();
    rbit = 1'b1; tick(2);
    rbit = 1'b0; tick(3);
  endtask

  initial begin
    rst = 1'b1; raw = 1'b1; dsel = 1'b1; en = 1'b1; rbit = 1'b0;
    tick(3);
    chk("R8 irq after reset", irq_n, 1'b1);
    chk("R8 level in reset", level, 1'b0);
    chk("R8 drv in reset", drv, 1'b0);
    rst = 1'b0;
    tick(6);
    chk("R8 no event from initial high", irq_n, 1'b1);
    chk("R1 level after release", level, 1'b1);
    chk("R2 drv after release", drv, 1'b1);

    // Sweep path select, enable and both edge directions
    for (int s = 0; s < 2; s++) begin
      for (int e = 0; e < 2; e++) begin
        for (int d = 0; d < 2; d++) begin
          logic exp_low;
          rearm();
          dsel = s[0]; en = e[0];
          raw = ~raw;
          tick(2);
          chk("R1 level not yet moved", level, ~raw);
          tick(1);
          chk("R1 level latency", level, raw);
          chk("R2 drv follows level", drv, raw);
          chk("R3 irq not before latency", irq_n, 1'b1);
          tick(1);
          exp_low = s[0] & e[0];
          chk(s[0] ? "R3/R5 irq after edge" : "R4 no irq when not selected",
              irq_n, ~exp_low);
          if (s[0] && !e[0]) begin
            en = 1'b1; tick(2);
            chk("R5 masked event appears", irq_n, 1'b0);
          end
          if (!s[0]) begin
            en = 1'b1; tick(2);
            chk("R4 nothing latched", irq_n, 1'b1);
          end
        end
      end
    end

    // R6: toggles while asserted, then clear sequence; R9: hold high
    dsel = 1'b1; en = 1'b1;
    rearm();
    raw = ~raw; tick(4);
    chk("R3 asserted", irq_n, 1'b0);
    raw = ~raw; tick(4);
    raw = ~raw; tick(4);
    chk("R6 held through toggles", irq_n, 1'b0);
    rbit = 1'b1; tick(6);
    chk("R9 held while bit high", irq_n, 1'b0);
    rbit = 1'b0; tick(3);
    chk("R6 cleared after high-low", irq_n, 1'b1);

    // R7: change during re-arm high is not an event
    rbit = 1'b1; tick(1);
    raw = ~raw; tick(5);
    rbit = 1'b0; tick(6);
    chk("R7 no event from change during re-arm", irq_n, 1'b1);
    chk("R1 level after re-arm change", level, raw);
    raw = ~raw; tick(4);
    chk("R7 detection resumes", irq_n, 1'b0);
    en = 1'b0; tick(2);
    chk("R5 mask releases pin", irq_n, 1'b1);
    raw = 1'b0; tick(4);
    chk("R2 driver off while low", drv, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule